// File: doc/BRIEF.md
# Virtual-Wire Interrupt Level Decoder

This block converts legacy interrupt messages that arrive from the link into four steady interrupt levels, one for each virtual wire (A, B, C, D). Each message names a wire and says whether to raise or lower it. The block stores one level bit per wire. An assert message sets the bit and a deassert message clears it. Message events come in on a valid/ready handshake that is always ready, so one message is taken on every cycle where valid is high.

Each stored level is merged with an external active-low interrupt request pin for the same line. Each pin first passes through a two-stage synchronizer. A line's output is pulled low, meaning active, while its stored wire level is set or its synchronized pin is low. This lets both sources share one level-sensitive, active-low interrupt input of an interrupt controller.

The message path works only while the root-complex mode enable is high. With the enable low, messages are dropped and all stored levels are held clear.

Top module: `vwire_irq_decoder`

## Requirements
- R1: While synchronous reset `rst` is high, and on the cycle after it, every stored level is clear and every synchronizer stage reads inactive. So `intOutN` is 4'b1111 after reset.
- R2: In root-complex mode, a message with `msgValid`=1 and `msgAssert`=1 sets the level of the wire named by `msgPin` (0=A, 1=B, 2=C, 3=D). Bit `msgPin` of `intOutN` goes low after the next rising edge.
- R3: In root-complex mode, a message with `msgValid`=1 and `msgAssert`=0 clears the named wire's level. Its `intOutN` bit returns high after the next rising edge, unless the external pin holds the line active.
- R4: An assert to a wire whose level is already set, or a deassert to a wire whose level is already clear, leaves `intOutN` unchanged.
- R5: A level on `extIrqN[i]` shows at `intOutN[i]` after exactly two rising edges, not after one.
- R6: `intOutN[i]` is low exactly while wire level i is set or the synchronized `extIrqN[i]` is low. This holds for all combinations of the four levels and the four pins.
- R7: While `rcMode` is low, messages have no effect on any level.
- R8: A cycle with `rcMode` low clears all four stored levels. They stay clear after the mode returns.
- R9: `msgReady` is high at all times outside reset.
- R10: A message changes only the level of the wire it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rcMode | input | 1 | Root-complex mode enable; the message path works only when high |
| msgValid | input | 1 | A message event is present |
| msgReady | output | 1 | The block takes the message; always high |
| msgAssert | input | 1 | 1 = assert message, 0 = deassert message |
| msgPin | input | 2 | Wire code: 0=A, 1=B, 2=C, 3=D |
| extIrqN | input | 4 | External interrupt request pins, active low, asynchronous |
| intOutN | output | 4 | Merged interrupt lines, active low, level-sensitive |

## Verification
The assertions assume that each message event names exactly one wire, so the set and clear strobes together are at most one-hot. They also assume that the reset input is held high from time zero until the first edges have passed. The bench drives every message and pin change at the falling edge and holds `rst` high from the start. In the sweep it sets the levels one wire per message, which keeps it within these assumptions. It waits the full synchronizer depth before it compares the merged outputs.

// File: rtl/vwire_pkg.sv
package vwire_pkg;
  localparam int VW_COUNT = 4;
  localparam int PIN_W = $clog2(VW_COUNT);

  typedef struct packed {
    logic [VW_COUNT-1:0] setMask;
    logic [VW_COUNT-1:0] clrMask;
    logic                clearAll;
  } vwStrobes_t;
endpackage

// File: rtl/vwire_ctrl.sv
module vwire_ctrl
  import vwire_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rcMode,
  input  logic             msgValid,
  input  logic             msgAssert,
  input  logic [PIN_W-1:0] msgPin,
  output vwStrobes_t       strobes
);
  logic [VW_COUNT-1:0] hit;

  generate
    for (genvar i = 0; i < VW_COUNT; i++) begin : g_dec
      always_comb begin
        hit[i]                = msgValid && rcMode && (msgPin == PIN_W'(i));
        strobes.setMask[i]    = hit[i] && msgAssert;
        strobes.clrMask[i]    = hit[i] && !msgAssert;
      end
    end
  endgenerate

  always_comb strobes.clearAll = rst || !rcMode;

  // R7: no strobe leaves the control outside root-complex mode
  assert_ignore_outside_rc_R7: assert property (@(posedge clk) disable iff (rst)
    !rcMode |-> (strobes.setMask == '0 && strobes.clrMask == '0));

  // R10: one message touches at most one wire
  assert_single_wire_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes.setMask | strobes.clrMask));
endmodule

// File: rtl/vwire_datapath.sv
module vwire_datapath
  import vwire_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  vwStrobes_t          strobes,
  input  logic [VW_COUNT-1:0] extIrqN,
  output logic [VW_COUNT-1:0] intOutN
);
  logic [VW_COUNT-1:0]    wireLevel;
  logic [VW_COUNT-1:0]    extActive;
  logic [SYNC_STAGES-1:0] syncChain [VW_COUNT];

  always_ff @(posedge clk) begin
    if (strobes.clearAll) wireLevel <= '0;
    else wireLevel <= (wireLevel | strobes.setMask) & ~strobes.clrMask;
  end

  generate
    for (genvar i = 0; i < VW_COUNT; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) syncChain[i] <= '1;
        else syncChain[i] <= {syncChain[i][SYNC_STAGES-2:0], extIrqN[i]};
      end
      always_comb extActive[i] = !syncChain[i][SYNC_STAGES-1];

      // R2: a set strobe leaves the wire active
      assert_set_level_R2: assert property (@(posedge clk) disable iff (rst)
        (strobes.setMask[i] && !strobes.clearAll) |=> !intOutN[i]);

      // R4: repeated assert keeps every level unchanged
      assert_repeat_set_R4: assert property (@(posedge clk) disable iff (rst)
        (strobes.setMask[i] && wireLevel[i] && !strobes.clearAll) |=> $stable(wireLevel));
    end
  endgenerate

  always_comb intOutN = ~(wireLevel | extActive);

  // R1: reset leaves every output inactive
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (intOutN == '1));

  // R8: a clear cycle empties all levels
  assert_mode_clear_R8: assert property (@(posedge clk) disable iff (rst)
    strobes.clearAll |=> (wireLevel == '0));
endmodule

// File: rtl/vwire_irq_decoder.sv
module vwire_irq_decoder
  import vwire_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rcMode,
  input  logic                msgValid,
  output logic                msgReady,
  input  logic                msgAssert,
  input  logic [PIN_W-1:0]    msgPin,
  input  logic [VW_COUNT-1:0] extIrqN,
  output logic [VW_COUNT-1:0] intOutN
);
  vwStrobes_t strobes;

  assign msgReady = 1'b1;

  vwire_ctrl u_ctrl (
    .clk(clk), .rst(rst), .rcMode(rcMode), .msgValid(msgValid),
    .msgAssert(msgAssert), .msgPin(msgPin), .strobes(strobes)
  );

  vwire_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .extIrqN(extIrqN), .intOutN(intOutN)
  );
endmodule

// File: tb/tb_vwire_irq_decoder.sv
module tb_vwire_irq_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rcMode = 1'b0;
  logic msgValid = 1'b0;
  logic msgAssert = 1'b0;
  logic [1:0] msgPin = 2'd0;
  logic [3:0] extIrqN = 4'hF;
  logic msgReady;
  logic [3:0] intOutN;

  int checks = 0;
  int failures = 0;
  logic [3:0] expLev = 4'h0;

  always #5 clk = ~clk;

  vwire_irq_decoder dut (
    .clk(clk), .rst(rst), .rcMode(rcMode), .msgValid(msgValid), .msgReady(msgReady),
    .msgAssert(msgAssert), .msgPin(msgPin), .extIrqN(extIrqN), .intOutN(intOutN)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sendMsg(input logic as, input int pin);
    msgValid = 1'b1;
    msgAssert = as;
    msgPin = 2'(pin);
    cycle();
    msgValid = 1'b0;
    if (rcMode) begin
      if (as) expLev[pin] = 1'b1;
      else expLev[pin] = 1'b0;
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    cycle();
    cycle();
    check("R1 reset idle", intOutN, 4'hF);
    rst = 1'b0;
    rcMode = 1'b1;
    cycle();
    check("R1 after reset", intOutN, 4'hF);
    check("R9 ready", {3'b000, msgReady}, 4'h1);

    for (int p = 0; p < 4; p++) begin
      sendMsg(1'b1, p);
      check("R2 assert / R10 others", intOutN, ~(4'h1 << p));
      sendMsg(1'b1, p);
      check("R4 repeat assert", intOutN, ~(4'h1 << p));
      sendMsg(1'b0, p);
      check("R3 deassert", intOutN, 4'hF);
      sendMsg(1'b0, p);
      check("R4 repeat deassert", intOutN, 4'hF);
    end

    // R5 synchronizer delay
    extIrqN = 4'b1011;
    cycle();
    check("R5 one edge", intOutN, 4'hF);
    cycle();
    check("R5 two edges", intOutN, 4'b1011);
    sendMsg(1'b1, 2);
    sendMsg(1'b0, 2);
    check("R3 ext holds line", intOutN, 4'b1011);
    extIrqN = 4'hF;
    cycle();
    cycle();
    check("R5 release", intOutN, 4'hF);

    // R6 sweep over all level and pin combinations
    for (int lp = 0; lp < 16; lp++) begin
      for (int w = 0; w < 4; w++) sendMsg(lp[w], w);
      for (int ep = 0; ep < 16; ep++) begin
        extIrqN = ~4'(ep);
        cycle();
        cycle();
        check("R6 merge", intOutN, ~(expLev | 4'(ep)));
      end
    end
    extIrqN = 4'hF;
    for (int w = 0; w < 4; w++) sendMsg(1'b0, w);
    cycle();
    cycle();

    // R7 ignored outside root-complex mode
    rcMode = 1'b0;
    cycle();
    for (int w = 0; w < 4; w++) begin
      sendMsg(1'b1, w);
      check("R7 ignored", intOutN, 4'hF);
    end

    // R8 leaving mode clears levels
    rcMode = 1'b1;
    for (int w = 0; w < 4; w++) sendMsg(1'b1, w);
    check("R8 all set", intOutN, 4'h0);
    rcMode = 1'b0;
    cycle();
    rcMode = 1'b1;
    expLev = 4'h0;
    cycle();
    check("R8 cleared", intOutN, 4'hF);
    check("R9 ready", {3'b000, msgReady}, 4'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule